// File: doc/BRIEF.md
# Genetic Payload Optimizer Engine

This block searches for frame payloads that make a device under test respond as slowly as possible. It holds a small population of short chromosomes. Each chromosome is expanded into a payload of a chosen length, and that payload is streamed to a frame generator. The payload repeats frame after frame while an outside latency meter watches the device. When the meter returns a fitness figure for the current candidate, the engine finishes the frame in flight and moves on to the next candidate. A larger latency counts as a better candidate.

Once every member of a generation has a fitness, the engine breeds the next generation. It picks parents by binary tournament, joins them at one random cut point and mutates every bit with a probability set by software. It then evaluates the new members in the same way. The first population comes from a free-running 32-bit LFSR that is seeded at reset. A run starts with a start pulse. It ends when a fitness reaches the target, or when the configured number of generations has been evaluated. The best chromosome and its fitness then stay on the outputs until the next start.

Top module: `gpo_engine`

## Requirements
- R1: After reset, done, pay_valid and fit_ready are low and best_fit is zero.
- R2: A start pulse in the idle or finished state latches the configuration and fills the population from the LFSR. With the default 32-bit chromosome, the first generation's members are pairwise distinct.
- R3: Every payload frame has L bytes, where L is cfg_len clamped to the range 1..MAX_LEN (0 gives 1). Byte i of a frame is byte (i mod CHROM_BYTES) of the candidate chromosome, and byte 0 is bits 7:0. pay_last is high on the final byte only.
- R4: While pay_valid is high and pay_ready is low, pay_valid, pay_data and pay_last hold their values.
- R5: A candidate's frame repeats until one fitness value is accepted for it. After that, fit_ready stays low until the frame in flight ends, and the next frame belongs to the next candidate. Candidates are scored in index order.
- R6: best_fit and best_chrom hold the highest fitness accepted in the run and the candidate that earned it, with the earliest candidate winning a tie. They stay unchanged from done until the next start.
- R7: With no target hit, the run ends after cfg_max_gen generations (0 counts as 1). That is exactly cfg_max_gen*POP fitness values. gen_idx equals the 0-based generation being scored. While done is high, pay_valid and fit_ready are low.
- R8: When an accepted fitness is at least cfg_target, done rises once that candidate's current frame ends, and no further fitness is taken.
- R9: With cfg_mut_thr = 0, every child equals the bits of one previous-generation member at and above a cut position c, combined with the bits of another previous member below c, for some c in 0..W-1.
- R10: Each chromosome bit of a child flips when a random byte is below cfg_mut_thr, so the flip probability is cfg_mut_thr/256. With 255, children fall outside the set that R9 describes.
- R11: A start pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (idle or finished state only) |
| cfg_len | input | LEN_W | Requested payload length in bytes |
| cfg_max_gen | input | GEN_W | Generation limit |
| cfg_target | input | FIT_W | Fitness that ends the run early |
| cfg_mut_thr | input | 8 | Mutation threshold per bit |
| fit_valid | input | 1 | Fitness value offered |
| fit_ready | output | 1 | Engine accepts a fitness value |
| fit_value | input | FIT_W | Latency figure of the current candidate |
| pay_valid | output | 1 | Payload byte valid |
| pay_ready | input | 1 | Frame generator takes the byte |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final byte of a frame |
| cand_chrom | output | 8*CHROM_BYTES | Chromosome being evaluated |
| gen_idx | output | GEN_W | Generation being evaluated |
| done | output | 1 | Run finished |
| best_chrom | output | 8*CHROM_BYTES | Best chromosome of the run |
| best_fit | output | FIT_W | Best fitness of the run |

## Verification
The bench builds the engine with its defaults: four members, four-byte chromosomes, an 11-bit length field and a 1500-byte ceiling. With these values a full-length frame and the over-range clamp both fit in a short run. Four members also make the R9 search cheap, because the bench can try every pair of previous members and every cut position for each child. The wide 32-bit chromosome makes first-generation duplicates impossible, and it makes a fully mutated child that a crossover could also produce vanishingly rare.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    localparam int          RNG_W    = 32;
    localparam logic [31:0] RNG_TAPS = 32'h8020_0003;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT,
        ST_EMIT,
        ST_SEL_A,
        ST_SEL_B,
        ST_CROSS,
        ST_MUTATE,
        ST_STORE,
        ST_COMMIT,
        ST_DONE
    } eng_state_e;

    // One step of a right-shifting Galois register; a nonzero state never maps to zero.
    function automatic logic [31:0] rng_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ RNG_TAPS) : (s >> 1);
    endfunction

    function automatic logic [15:0] clamp_len(input logic [15:0] req, input logic [15:0] lim);
        if (req == 16'd0) return 16'd1;
        if (req > lim)    return lim;
        return req;
    endfunction

endpackage

// File: rtl/gpo_rng.sv
module gpo_rng
    import gpo_pkg::*;
#(
    parameter logic [31:0] SEED = 32'h1D87_2B41
) (
    input  logic             clk,
    input  logic             rst,
    output logic [RNG_W-1:0] rnd
);
    localparam logic [31:0] SEED_NZ = (SEED == 32'd0) ? 32'h0000_0001 : SEED;

    logic [RNG_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED_NZ;
        else     state_q <= rng_step(state_q);
    end

    assign rnd = state_q;

    AST_RNG_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0); // R2

endmodule

// File: rtl/gpo_popstore.sv
module gpo_popstore #(
    parameter int POP   = 4,
    parameter int CW    = 32,
    parameter int FIT_W = 16,
    parameter int IW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic [IW-1:0]    ld_idx,
    input  logic [CW-1:0]    ld_chrom,
    input  logic             fit_we,
    input  logic [IW-1:0]    fit_idx,
    input  logic [FIT_W-1:0] fit_val,
    input  logic             kid_we,
    input  logic [IW-1:0]    kid_idx,
    input  logic [CW-1:0]    kid_chrom,
    input  logic             commit,
    input  logic [IW-1:0]    rd_idx,
    output logic [CW-1:0]    rd_chrom,
    input  logic [IW-1:0]    ta_idx,
    input  logic [IW-1:0]    tb_idx,
    output logic [CW-1:0]    win_chrom
);
    logic [CW-1:0]    cur_chrom [POP];
    logic [FIT_W-1:0] cur_fit   [POP];
    logic [CW-1:0]    nxt_chrom [POP];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < POP; i++) begin
                cur_chrom[i] <= '0;
                cur_fit[i]   <= '0;
                nxt_chrom[i] <= '0;
            end
        end else begin
            if (ld_we)  cur_chrom[ld_idx] <= ld_chrom;
            if (fit_we) cur_fit[fit_idx]  <= fit_val;
            if (kid_we) nxt_chrom[kid_idx] <= kid_chrom;
            if (commit) begin
                for (int i = 0; i < POP; i++) cur_chrom[i] <= nxt_chrom[i];
            end
        end
    end

    assign rd_chrom  = cur_chrom[rd_idx];
    // Binary tournament: the higher stored fitness wins, the first draw on a tie.
    assign win_chrom = (cur_fit[ta_idx] >= cur_fit[tb_idx]) ? cur_chrom[ta_idx] : cur_chrom[tb_idx];

    AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ld_we && (kid_we || commit || fit_we))); // R2

endmodule

// File: rtl/gpo_streamer.sv
module gpo_streamer #(
    parameter int CB    = 4,
    parameter int LEN_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [8*CB-1:0] chrom,
    input  logic [LEN_W-1:0] len,
    input  logic            ready,
    output logic            valid,
    output logic [7:0]      data,
    output logic            last,
    output logic            frame_done
);
    localparam int SW = (CB > 1) ? $clog2(CB) : 1;

    logic [7:0]       lanes [CB];
    logic [LEN_W-1:0] pos_q;
    logic [SW-1:0]    sel_q;
    logic             fire;

    for (genvar b = 0; b < CB; b++) begin : g_lane
        assign lanes[b] = chrom[8*b +: 8];
    end

    assign valid      = en;
    assign data       = lanes[sel_q];
    assign last       = (pos_q == len - LEN_W'(1));
    assign fire       = valid && ready;
    assign frame_done = fire && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            sel_q <= '0;
        end else if (fire) begin
            if (last) begin
                pos_q <= '0;
                sel_q <= '0;
            end else begin
                pos_q <= pos_q + LEN_W'(1);
                sel_q <= (sel_q == SW'(CB - 1)) ? '0 : sel_q + SW'(1);
            end
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        en |-> (pos_q < len)); // R3
    AST_PAY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(data) && $stable(last))); // R4

endmodule

// File: rtl/gpo_engine.sv
module gpo_engine
    import gpo_pkg::*;
#(
    parameter int          POP         = 4,
    parameter int          CHROM_BYTES = 4,
    parameter int          FIT_W       = 16,
    parameter int          LEN_W       = 11,
    parameter int          MAX_LEN     = 1500,
    parameter int          GEN_W       = 8,
    parameter logic [31:0] SEED        = 32'h1D87_2B41
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [LEN_W-1:0]         cfg_len,
    input  logic [GEN_W-1:0]         cfg_max_gen,
    input  logic [FIT_W-1:0]         cfg_target,
    input  logic [7:0]               cfg_mut_thr,
    input  logic                     fit_valid,
    output logic                     fit_ready,
    input  logic [FIT_W-1:0]         fit_value,
    output logic                     pay_valid,
    input  logic                     pay_ready,
    output logic [7:0]               pay_data,
    output logic                     pay_last,
    output logic [8*CHROM_BYTES-1:0] cand_chrom,
    output logic [GEN_W-1:0]         gen_idx,
    output logic                     done,
    output logic [8*CHROM_BYTES-1:0] best_chrom,
    output logic [FIT_W-1:0]         best_fit
);
    localparam int CW = 8 * CHROM_BYTES;
    localparam int IW = (POP > 1) ? $clog2(POP) : 1;
    localparam int BW = $clog2(CW);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [GEN_W-1:0] max_gen;
        logic [FIT_W-1:0] target;
        logic [7:0]       thr;
    } run_cfg_t;

    eng_state_e       state_q;
    run_cfg_t         cfg_q;
    logic [IW-1:0]    idx_q, kid_q;
    logic [GEN_W-1:0] gen_q;
    logic             fit_pend_q, hit_pend_q, best_seen_q;
    logic [CW-1:0]    par_a_q, par_b_q, child_q, best_chrom_q;
    logic [BW-1:0]    bit_q;
    logic [FIT_W-1:0] best_fit_q;

    logic [RNG_W-1:0] rnd;
    logic [CW-1:0]    win_chrom, cur_chrom, cut_mask;
    logic [IW-1:0]    tour_a, tour_b;
    logic [BW-1:0]    cut;
    logic             fit_fire, frame_done, advance, hit_now, last_gen, emit;

    gpo_rng #(.SEED(SEED)) u_rng (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    assign tour_a   = IW'(rnd[15:0] % 16'(POP));
    assign tour_b   = IW'(rnd[31:16] % 16'(POP));
    assign cut      = BW'(rnd[23:16] % 8'(CW));
    assign cut_mask = (CW'(1) << cut) - CW'(1);

    gpo_popstore #(.POP(POP), .CW(CW), .FIT_W(FIT_W), .IW(IW)) u_pop (
        .clk       (clk),
        .rst       (rst),
        .ld_we     (state_q == ST_INIT),
        .ld_idx    (idx_q),
        .ld_chrom  (rnd[CW-1:0]),
        .fit_we    (fit_fire),
        .fit_idx   (idx_q),
        .fit_val   (fit_value),
        .kid_we    (state_q == ST_STORE),
        .kid_idx   (kid_q),
        .kid_chrom (child_q),
        .commit    (state_q == ST_COMMIT),
        .rd_idx    (idx_q),
        .rd_chrom  (cur_chrom),
        .ta_idx    (tour_a),
        .tb_idx    (tour_b),
        .win_chrom (win_chrom)
    );

    assign emit = (state_q == ST_EMIT);

    gpo_streamer #(.CB(CHROM_BYTES), .LEN_W(LEN_W)) u_stream (
        .clk        (clk),
        .rst        (rst),
        .en         (emit),
        .chrom      (cur_chrom),
        .len        (cfg_q.len),
        .ready      (pay_ready),
        .valid      (pay_valid),
        .data       (pay_data),
        .last       (pay_last),
        .frame_done (frame_done)
    );

    assign fit_ready = emit && !fit_pend_q;
    assign fit_fire  = fit_valid && fit_ready;
    assign advance   = frame_done && (fit_pend_q || fit_fire);
    assign hit_now   = hit_pend_q || (fit_fire && (fit_value >= cfg_q.target));
    assign last_gen  = (({1'b0, gen_q} + (GEN_W+1)'(1)) >= {1'b0, cfg_q.max_gen});

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            cfg_q        <= '{len: LEN_W'(1), max_gen: GEN_W'(1), target: '1, thr: '0};
            idx_q        <= '0;
            kid_q        <= '0;
            gen_q        <= '0;
            fit_pend_q   <= 1'b0;
            hit_pend_q   <= 1'b0;
            best_seen_q  <= 1'b0;
            par_a_q      <= '0;
            par_b_q      <= '0;
            child_q      <= '0;
            bit_q        <= '0;
            best_fit_q   <= '0;
            best_chrom_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        cfg_q.len     <= LEN_W'(clamp_len(16'(cfg_len), 16'(MAX_LEN)));
                        cfg_q.max_gen <= (cfg_max_gen == '0) ? GEN_W'(1) : cfg_max_gen;
                        cfg_q.target  <= cfg_target;
                        cfg_q.thr     <= cfg_mut_thr;
                        idx_q         <= '0;
                        gen_q         <= '0;
                        fit_pend_q    <= 1'b0;
                        hit_pend_q    <= 1'b0;
                        best_seen_q   <= 1'b0;
                        best_fit_q    <= '0;
                        best_chrom_q  <= '0;
                        state_q       <= ST_INIT;
                    end
                end
                ST_INIT: begin
                    if (idx_q == IW'(POP - 1)) begin
                        idx_q   <= '0;
                        state_q <= ST_EMIT;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                ST_EMIT: begin
                    if (fit_fire && (!best_seen_q || (fit_value > best_fit_q))) begin
                        best_fit_q   <= fit_value;
                        best_chrom_q <= cur_chrom;
                        best_seen_q  <= 1'b1;
                    end
                    if (advance) begin
                        fit_pend_q <= 1'b0;
                        hit_pend_q <= 1'b0;
                        if (hit_now) begin
                            state_q <= ST_DONE;
                        end else if (idx_q == IW'(POP - 1)) begin
                            if (last_gen) begin
                                state_q <= ST_DONE;
                            end else begin
                                kid_q   <= '0;
                                state_q <= ST_SEL_A;
                            end
                        end else begin
                            idx_q <= idx_q + IW'(1);
                        end
                    end else if (fit_fire) begin
                        fit_pend_q <= 1'b1;
                        hit_pend_q <= (fit_value >= cfg_q.target);
                    end
                end
                ST_SEL_A: begin
                    par_a_q <= win_chrom;
                    state_q <= ST_SEL_B;
                end
                ST_SEL_B: begin
                    par_b_q <= win_chrom;
                    state_q <= ST_CROSS;
                end
                ST_CROSS: begin
                    child_q <= (par_a_q & ~cut_mask) | (par_b_q & cut_mask);
                    bit_q   <= '0;
                    state_q <= ST_MUTATE;
                end
                ST_MUTATE: begin
                    if (rnd[31:24] < cfg_q.thr) child_q[bit_q] <= ~child_q[bit_q];
                    if (bit_q == BW'(CW - 1)) state_q <= ST_STORE;
                    else                      bit_q   <= bit_q + BW'(1);
                end
                ST_STORE: begin
                    if (kid_q == IW'(POP - 1)) begin
                        state_q <= ST_COMMIT;
                    end else begin
                        kid_q   <= kid_q + IW'(1);
                        state_q <= ST_SEL_A;
                    end
                end
                ST_COMMIT: begin
                    gen_q   <= gen_q + GEN_W'(1);
                    idx_q   <= '0;
                    state_q <= ST_EMIT;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cand_chrom = cur_chrom;
    assign gen_idx    = gen_q;
    assign done       = (state_q == ST_DONE);
    assign best_chrom = best_chrom_q;
    assign best_fit   = best_fit_q;

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!pay_valid && !fit_ready)); // R7
    AST_GEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        emit |-> ({1'b0, gen_q} < {1'b0, cfg_q.max_gen})); // R7
    AST_ONE_FIT: assert property (@(posedge clk) disable iff (rst)
        (fit_valid && fit_ready && !(pay_valid && pay_ready && pay_last)) |=> !fit_ready); // R5
    AST_BEST_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(best_fit) && $stable(best_chrom))); // R6
    AST_BEST_MONO: assert property (@(posedge clk) disable iff (rst)
        (!start) |=> (best_fit >= $past(best_fit))); // R6

endmodule

// File: tb/tb_gpo_engine.sv
module tb_gpo_engine;
    localparam int POP = 4;
    localparam int CB  = 4;
    localparam int CW  = 8 * CB;

    logic           clk = 1'b0;
    logic           rst, start;
    logic [10:0]    cfg_len;
    logic [7:0]     cfg_max_gen, cfg_mut_thr;
    logic [15:0]    cfg_target, fit_value;
    logic           fit_valid, fit_ready, pay_valid, pay_ready, pay_last, done;
    logic [7:0]     pay_data, gen_idx;
    logic [CW-1:0]  cand_chrom, best_chrom;
    logic [15:0]    best_fit;

    always #4 clk = ~clk;

    gpo_engine dut (
        .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len), .cfg_max_gen(cfg_max_gen),
        .cfg_target(cfg_target), .cfg_mut_thr(cfg_mut_thr), .fit_valid(fit_valid),
        .fit_ready(fit_ready), .fit_value(fit_value), .pay_valid(pay_valid),
        .pay_ready(pay_ready), .pay_data(pay_data), .pay_last(pay_last),
        .cand_chrom(cand_chrom), .gen_idx(gen_idx), .done(done),
        .best_chrom(best_chrom), .best_fit(best_fit)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [CW-1:0] prev_g [POP];
    logic [CW-1:0] cur_g  [POP];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit reachable(input logic [CW-1:0] c);
        for (int p = 0; p < POP; p++)
            for (int q = 0; q < POP; q++)
                for (int k = 0; k < CW; k++) begin
                    logic [CW-1:0] m;
                    m = (CW'(1) << k) - CW'(1);
                    if (((prev_g[p] & ~m) | (prev_g[q] & m)) == c) return 1'b1;
                end
        return 1'b0;
    endfunction

    function automatic logic [15:0] fit_for(input int mode, input int n);
        case (mode)
            0:       return 16'($urandom % 61440);
            1:       return 16'd77;
            default: return (n == 5) ? 16'd500 : 16'd100;
        endcase
    endfunction

    task automatic run_job(input int len, input int maxg, input int tgt, input int thr,
                           input int mode, input int exp_fits, input bit mid_start);
        int exp_len, pos, fit_cnt, e_frame, e_hold, e_r5, e_gen, bad_dist, nonreach, reached;
        bit pend, have_prev, prev_adv, hold, pulsed, fin;
        logic [CW-1:0] fchrom, prev_chrom, ebchrom;
        logic [15:0] ebest, v;
        logic [7:0] hd;
        bit hl, r;
        exp_len = (len == 0) ? 1 : ((len > 1500) ? 1500 : len);
        pos = 0; fit_cnt = 0; e_frame = 0; e_hold = 0; e_r5 = 0; e_gen = 0;
        bad_dist = 0; nonreach = 0; reached = 0;
        pend = 0; have_prev = 0; prev_adv = 0; hold = 0; pulsed = 0; fin = 0;
        fchrom = '0; prev_chrom = '0; ebchrom = '0; ebest = '0; hd = '0; hl = 0;
        @(negedge clk);
        cfg_len = 11'(len); cfg_max_gen = 8'(maxg); cfg_target = 16'(tgt);
        cfg_mut_thr = 8'(thr); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 60000; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            fit_valid = 1'b0;
            if (hold && (!pay_valid || pay_data != hd || pay_last != hl)) e_hold++;
            if (done) begin fin = 1; break; end
            if (mid_start && !pulsed && fit_cnt == 3) begin start = 1'b1; pulsed = 1; end
            if (fit_ready) begin
                if (pend) e_r5++;
                else if ($urandom % 3 == 0) begin
                    v = fit_for(mode, fit_cnt);
                    fit_valid = 1'b1; fit_value = v; pend = 1;
                    if (gen_idx != 8'(fit_cnt / POP)) e_gen++;
                    if (fit_cnt == 0 || v > ebest) begin ebest = v; ebchrom = cand_chrom; end
                    cur_g[fit_cnt % POP] = cand_chrom;
                    fit_cnt++;
                    if (fit_cnt % POP == 0) begin
                        if (fit_cnt == POP) begin
                            for (int i = 0; i < POP; i++)
                                for (int j = i + 1; j < POP; j++)
                                    if (cur_g[i] == cur_g[j]) bad_dist++;
                        end else begin
                            for (int k = 0; k < POP; k++) begin
                                reached++;
                                if (!reachable(cur_g[k])) nonreach++;
                            end
                        end
                        for (int k = 0; k < POP; k++) prev_g[k] = cur_g[k];
                    end
                end
            end
            r = ($urandom % 4) != 0;
            pay_ready = r;
            hold = pay_valid && !r; hd = pay_data; hl = pay_last;
            if (pay_valid && r) begin
                if (pos == 0) begin
                    fchrom = cand_chrom;
                    if (have_prev && !prev_adv && cand_chrom != prev_chrom) e_r5++;
                end
                if (cand_chrom != fchrom) e_frame++;
                if (pay_data != fchrom[8*(pos % CB) +: 8]) e_frame++;
                if (pay_last != (pos == exp_len - 1)) e_frame++;
                if (pay_last) begin
                    have_prev = 1; prev_chrom = fchrom; prev_adv = pend; pend = 0; pos = 0;
                end else pos++;
            end
        end
        fit_valid = 1'b0; pay_ready = 1'b0; start = 1'b0;
        chk(fin, "R7", "run reached done", fin, 1);
        chk(fit_cnt == exp_fits, (mode == 2) ? "R8" : (mid_start ? "R11" : "R7"),
            "fitness values taken", fit_cnt, exp_fits);
        chk(gen_idx == 8'((exp_fits - 1) / POP), "R7", "final gen_idx", gen_idx, (exp_fits - 1) / POP);
        chk(e_gen == 0, "R7", "gen_idx during scoring errors", e_gen, 0);
        chk(e_frame == 0, "R3", "frame content/length errors", e_frame, 0);
        chk(e_hold == 0, "R4", "hold-while-stalled errors", e_hold, 0);
        chk(e_r5 == 0, "R5", "fitness handshake/repeat errors", e_r5, 0);
        chk(bad_dist == 0, "R2", "duplicate initial members", bad_dist, 0);
        chk(best_fit == ebest, "R6", "best_fit", best_fit, ebest);
        chk(best_chrom == ebchrom, "R6", "best_chrom", best_chrom, ebchrom);
        if (reached > 0 && thr == 0)
            chk(nonreach == 0, "R9", "children outside crossover set", nonreach, 0);
        if (reached > 0 && thr == 255)
            chk(nonreach > 0, "R10", "mutated children outside crossover set", nonreach, 1);
        repeat (6) @(negedge clk);
        chk(done && !pay_valid && !fit_ready, "R7", "quiet while done",
            {done, pay_valid, fit_ready}, 3'b100);
        chk(best_fit == ebest && best_chrom == ebchrom, "R6", "best held after done", best_fit, ebest);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R7 watchdog: actual=190000 cycles expected=fewer");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; fit_valid = 1'b0; fit_value = '0; pay_ready = 1'b0;
        cfg_len = 11'd8; cfg_max_gen = 8'd1; cfg_target = 16'hFFFF; cfg_mut_thr = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done, "R1", "done after reset", done, 0);
        chk(!pay_valid, "R1", "pay_valid after reset", pay_valid, 0);
        chk(!fit_ready, "R1", "fit_ready after reset", fit_ready, 0);
        chk(best_fit == 0, "R1", "best_fit after reset", best_fit, 0);
        // random fitness, three generations, no mutation: R3 R4 R5 R6 R7 R9
        run_job(7, 3, 16'hFFFF, 0, 0, 12, 1'b0);
        // zero length and zero generation limit: R3 R7
        run_job(0, 0, 16'hFFFF, 0, 0, 4, 1'b0);
        // over-range length clamps to 1500: R3
        run_job(2000, 1, 16'hFFFF, 0, 0, 4, 1'b0);
        // target hit by sixth candidate: R8
        run_job(5, 5, 500, 0, 2, 6, 1'b0);
        // full mutation: R10
        run_job(3, 2, 16'hFFFF, 255, 0, 8, 1'b0);
        // start during a run is ignored: R11
        run_job(4, 2, 16'hFFFF, 0, 0, 8, 1'b1);
        // equal fitness everywhere, earliest candidate is best: R6
        run_job(6, 1, 16'hFFFF, 0, 1, 4, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule